// File: doc/BRIEF.md
# Dual-Role Byte-Wide SPI Controller

This block moves one byte at a time over a four-wire serial bus and can act either as the bus master or as a bus slave. A single configuration byte sets the role and the master clock divider. It also controls whether pin inputs are retimed, where the slave's select comes from, and which event raises the interrupt. Every transfer is 8 bits, most significant bit first, in SPI mode 0. In that mode the clock idles low, data is sampled on the rising edge and the next bit is shifted out on the falling edge.

As master, the block divides the system clock by a power of two and drives the serial clock. Writing a byte to the transmit buffer while the engine is idle starts a transfer. As slave, the block follows an external serial clock. It is selected either by the external active-low select pin or by an internal select bit held in the configuration byte. The configuration can only change while the block is disabled. The serial data output `sdo` carries MOSI in master mode and MISO in slave mode. The serial data input `sdi` carries the other direction.

Top module: `spi_port`

## Requirements
- R1: After reset the configuration byte reads 0x00. A write made while `en` is low is read back unchanged on `cfg_rdata`. The field layout is: bit 0 role (0 master, 1 slave), bit 1 interrupt source, bit 2 select source (active low), bit 3 internal select level, bit 4 input-retiming bypass, bits 7:5 divider code.
- R2: A configuration write made while `en` is high is ignored, and `cfg_rdata` keeps its previous value.
- R3: In master mode each half period of `sclk_out` lasts 2^code system clocks, so the serial clock period is the system clock period times 2^(code+1). Each transfer has exactly 8 rising edges.
- R4: In master mode, writing the transmit buffer while idle starts a transfer. The byte goes out on `sdo` MSB first, stable at each rising edge. The 8 bits sampled from `sdi` on the rising edges appear on `rx_data` when the transfer ends.
- R5: In slave mode with bit 2 = 1, the external `csn_in` pin selects the block (low = selected). A selected slave shifts its transmit byte out on `sdo` and captures 8 bits from `sdi` on the rising edges of `sclk_in`. A deselected slave ignores `sclk_in`.
- R6: In slave mode with bit 2 = 0, bit 3 decides selection (0 = selected, 1 = not selected), and `csn_in` has no effect.
- R7: With bit 4 = 1 the pin inputs `sclk_in`, `sdi` and `csn_in` are used directly. With bit 4 = 0 they first pass through two retiming flops, which adds two system clocks of latency.
- R8: In slave mode, deselecting in the middle of a byte abandons it. `rx_data` and the done flag stay unchanged, and the next selection starts a fresh byte.
- R9: `irq` is a single-cycle pulse. With bit 1 = 0 it fires when the transmit buffer is moved into the shifter. With bit 1 = 1 it fires when a byte completes.
- R10: `st_tx_empty` and `st_done` are set by the buffer-moved and byte-complete events. They stay set until a `stat_re` pulse clears them.
- R11: `sclk_out` stays low while the block is disabled and whenever the block is in slave mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; configuration writes are only accepted while low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current configuration byte |
| tx_we | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | 8 | Transmit buffer write data |
| rx_data | output | 8 | Last completed received byte |
| stat_re | input | 1 | Status read strobe; clears both flags |
| st_tx_empty | output | 1 | Sticky flag: transmit buffer was moved into the shifter |
| st_done | output | 1 | Sticky flag: a byte transfer completed |
| irq | output | 1 | Interrupt pulse, source chosen by configuration bit 1 |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_in | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| csn_in | input | 1 | External active-low slave select pin |

## Verification
On every cycle, the assertions check the configuration freeze while enabled, that the interrupt never lasts beyond one cycle, that a completion interrupt always comes with the done flag, and that the serial clock output stays low when disabled or in slave mode. The divider rates, bit ordering, data captured in both roles, select-source choice, retiming latency and mid-byte abort can only be shown by the bench's scenarios. Those scenarios play the opposite end of the bus and compare whole bytes and edge spacing.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int CFG_W    = 8;
    localparam int CODE_W   = 3;
    // configuration bit positions
    localparam int B_MODE    = 0;
    localparam int B_IRQSEL  = 1;
    localparam int B_SSEN_N  = 2;
    localparam int B_SS      = 3;
    localparam int B_BYPASS  = 4;
    localparam int B_CODE_LO = 5;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } role_e;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bypass,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= din[i];
                s2_q <= s1_q;
            end
        end
        assign dout[i] = bypass ? din[i] : s2_q;
    end
endmodule

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   half;
    logic [CNT_W-1:0] limit;

    always_comb begin
        half  = (CNT_W+1)'(1) << code;
        limit = CNT_W'(half - 1'b1);
        tick  = run && (cnt_q == limit);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic [DATA_W-1:0] rx_data,
    input  logic             stat_re,
    output logic             st_tx_empty,
    output logic             st_done,
    output logic             irq,
    output logic             sclk_out,
    input  logic             sclk_in,
    output logic             sdo,
    input  logic             sdi,
    input  logic             csn_in
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [DATA_W-1:0] txb;
        logic              tx_full;
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] rsh;
        logic [DATA_W-1:0] rxd;
        logic [CNT_W-1:0]  cnt;
        logic              last;
        logic              active;
        logic              sclk;
        logic              sclk_p;
        logic              st_empty;
        logic              st_done;
        logic              irq;
    } state_t;

    state_t d, q;

    logic  csn_s, sclk_s, sdi_s;
    logic  tick, run, sel;
    logic  sample, shift, load, empty_ev, done_ev;
    logic  [DATA_W-1:0] rx_next;
    role_e role;

    spi_port_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .bypass (q.cfg[B_BYPASS]),
        .din    ({csn_in, sclk_in, sdi}),
        .dout   ({csn_s, sclk_s, sdi_s})
    );

    assign role = role_e'(q.cfg[B_MODE]);
    assign run  = en && (role == ROLE_MASTER) && q.active;
    assign sel  = en && (role == ROLE_SLAVE) &&
                  (q.cfg[B_SSEN_N] ? !csn_s : !q.cfg[B_SS]);

    spi_port_clkdiv #(.CODE_W(CODE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .code  (q.cfg[B_CODE_LO +: CODE_W]),
        .tick  (tick)
    );

    always_comb begin
        d        = q;
        sample   = 1'b0;
        shift    = 1'b0;
        load     = 1'b0;
        empty_ev = 1'b0;
        done_ev  = 1'b0;
        rx_next  = {q.rsh[DATA_W-2:0], sdi_s};
        d.sclk_p = sclk_s;

        if (cfg_we && !en) d.cfg = cfg_wdata;

        if (!en) begin
            d.active = 1'b0;
            d.sclk   = 1'b0;
            d.cnt    = '0;
            d.last   = 1'b0;
        end else if (role == ROLE_MASTER) begin
            if (!q.active) begin
                if (q.tx_full) begin
                    d.active = 1'b1;
                    d.cnt    = '0;
                    d.sclk   = 1'b0;
                    load     = 1'b1;
                end
            end else if (tick) begin
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                    sample = 1'b1;
                end else begin
                    d.sclk = 1'b0;
                    if (q.last) begin
                        d.active = 1'b0;
                        d.last   = 1'b0;
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
        end else begin
            d.sclk = 1'b0;
            if (!sel) begin
                // leaving mid-byte drops the partial byte
                d.active = 1'b0;
                d.last   = 1'b0;
                d.cnt    = '0;
            end else if (!q.active) begin
                d.active = 1'b1;
                d.cnt    = '0;
                load     = 1'b1;
            end else begin
                if (sclk_s && !q.sclk_p) sample = 1'b1;
                if (!sclk_s && q.sclk_p) begin
                    if (q.last) begin
                        d.last = 1'b0;
                        load   = 1'b1;
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
        end

        if (sample) begin
            d.rsh = rx_next;
            if (q.cnt == CNT_W'(DATA_W-1)) begin
                d.rxd   = rx_next;
                d.cnt   = '0;
                d.last  = 1'b1;
                done_ev = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (shift) d.sr = {q.sr[DATA_W-2:0], 1'b0};
        if (load) begin
            d.sr = q.txb;
            if (q.tx_full) begin
                d.tx_full = 1'b0;
                empty_ev  = 1'b1;
            end
        end

        if (tx_we) begin
            d.txb     = tx_wdata;
            d.tx_full = 1'b1;
        end

        d.st_empty = empty_ev | (q.st_empty & ~stat_re);
        d.st_done  = done_ev  | (q.st_done  & ~stat_re);
        d.irq      = q.cfg[B_IRQSEL] ? done_ev : empty_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_rdata   = q.cfg;
    assign rx_data     = q.rxd;
    assign st_tx_empty = q.st_empty;
    assign st_done     = q.st_done;
    assign irq         = q.irq;
    assign sclk_out    = q.sclk;
    assign sdo         = q.sr[DATA_W-1];
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       cfg_we,
    input logic [7:0] cfg_rdata,
    input logic       irq,
    input logic       st_done,
    input logic       sclk_out
);
    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg_we) |=> $stable(cfg_rdata));

    a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r10_done_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cfg_rdata[1]) |-> st_done);

    a_r11_slave_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] |-> !sclk_out);

    a_r11_disabled_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sclk_out);
endmodule

bind spi_port spi_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .irq       (irq),
    .st_done   (st_done),
    .sclk_out  (sclk_out)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, en, cfg_we, tx_we, stat_re, sclk_in, sdi, csn_in;
    logic [7:0] cfg_wdata, tx_wdata;
    logic [7:0] cfg_rdata, rx_data;
    logic       st_tx_empty, st_done, irq, sclk_out, sdo;

    int n_chk = 0;
    int n_err = 0;
    int irq_cnt = 0;

    spi_port u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_data(rx_data),
        .stat_re(stat_re), .st_tx_empty(st_tx_empty), .st_done(st_done), .irq(irq),
        .sclk_out(sclk_out), .sclk_in(sclk_in), .sdo(sdo), .sdi(sdi), .csn_in(csn_in)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b0; cfg_we = 1'b0; tx_we = 1'b0; stat_re = 1'b0;
        sclk_in = 1'b0; sdi = 1'b0; csn_in = 1'b1; cfg_wdata = '0; tx_wdata = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic set_cfg(logic [7:0] v);
        en = 1'b0; cfg_we = 1'b1; cfg_wdata = v; cyc(1); cfg_we = 1'b0;
    endtask

    task automatic write_tx(logic [7:0] v);
        tx_we = 1'b1; tx_wdata = v; cyc(1); tx_we = 1'b0;
    endtask

    task automatic clear_stat();
        stat_re = 1'b1; cyc(1); stat_re = 1'b0;
    endtask

    // bench acts as master on the slave pins, 6-cycle half period
    task automatic drive_bits(logic [7:0] mb, int nbits, output logic [7:0] cap);
        cap = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi = mb[7-i];
            cyc(6);
            cap = {cap[6:0], sdo};
            sclk_in = 1'b1;
            cyc(6);
            sclk_in = 1'b0;
        end
        cyc(6);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset cfg", cfg_rdata, 0);
        check("R9 reset irq", irq, 0);
        check("R11 reset sclk_out", sclk_out, 0);
        check("R10 reset flags", {st_tx_empty, st_done}, 0);
    endtask

    task automatic t_cfg_lock();
        set_cfg(8'h5A);
        check("R1 cfg readback", cfg_rdata, 8'h5A);
        en = 1'b1;
        cfg_we = 1'b1; cfg_wdata = 8'hA5; cyc(1); cfg_we = 1'b0;
        cyc(1);
        check("R2 cfg write ignored while enabled", cfg_rdata, 8'h5A);
        en = 1'b0;
        cyc(1);
    endtask

    task automatic t_master(int code, logic byp, logic isel, logic [7:0] tx, logic [7:0] rsp);
        int h = 1 << code;
        int nr = 0, nf = 0, tr = 0, tf = 0, base;
        logic prev = 1'b0;
        logic [7:0] cap = '0;
        set_cfg({3'(code), byp, 1'b1, 1'b1, isel, 1'b0});
        clear_stat();
        en = 1'b1;
        sdi = rsp[7];
        base = irq_cnt;
        write_tx(tx);
        for (int i = 0; i < 16*h + 10; i++) begin
            cyc(1);
            if (sclk_out && !prev) begin
                cap = {cap[6:0], sdo};
                nr++;
                if (nr == 1) tr = i;
            end
            if (!sclk_out && prev) begin
                nf++;
                if (nf == 1) tf = i;
                if (nf < 8) sdi = rsp[7-nf];
            end
            prev = sclk_out;
        end
        check("R4 master sdo byte", cap, tx);
        check("R4 master rx_data", rx_data, rsp);
        check("R3 master half period", tf - tr, h);
        check("R3 master rising edges", nr, 8);
        check("R10 master flags set", {st_tx_empty, st_done}, 2'b11);
        check("R9 master irq pulses", irq_cnt - base, 1);
        check("R11 master sclk idle low", sclk_out, 0);
        en = 1'b0;
        cyc(2);
    endtask

    task automatic t_slave_ext(logic byp, logic isel, logic [7:0] tx, logic [7:0] mb);
        logic [7:0] cap;
        int base;
        set_cfg({3'b000, byp, 1'b1, 1'b1, isel, 1'b1});
        clear_stat();
        write_tx(tx);
        en = 1'b1;
        base = irq_cnt;
        csn_in = 1'b0;
        cyc(6);
        drive_bits(mb, 8, cap);
        csn_in = 1'b1;
        cyc(4);
        check("R5 slave sdo byte", cap, tx);
        check("R5 slave rx_data", rx_data, mb);
        check("R10 slave done flag", st_done, 1);
        check("R9 slave irq pulses", irq_cnt - base, 1);
        check("R11 slave sclk_out low", sclk_out, 0);
        en = 1'b0;
        cyc(2);
    endtask

    task automatic t_stat_clear();
        clear_stat();
        check("R10 flags cleared by read", {st_tx_empty, st_done}, 0);
    endtask

    task automatic t_ext_ignored();
        logic [7:0] cap, old;
        old = rx_data;
        set_cfg({3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1});
        clear_stat();
        en = 1'b1;
        csn_in = 1'b1;
        drive_bits(8'h3C, 8, cap);
        check("R5 deselected slave done flag", st_done, 0);
        check("R5 deselected slave rx unchanged", rx_data, old);
        en = 1'b0;
        cyc(2);
    endtask

    task automatic t_internal_sel();
        logic [7:0] cap, old;
        // internal select active, pin says not selected
        set_cfg({3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
        clear_stat();
        write_tx(8'h96);
        csn_in = 1'b1;
        en = 1'b1;
        cyc(6);
        drive_bits(8'h4B, 8, cap);
        check("R6 internal select rx_data", rx_data, 8'h4B);
        check("R6 internal select sdo byte", cap, 8'h96);
        en = 1'b0;
        cyc(2);
        // internal select inactive, pin says selected
        old = rx_data;
        set_cfg({3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
        clear_stat();
        csn_in = 1'b0;
        en = 1'b1;
        cyc(6);
        drive_bits(8'hE1, 8, cap);
        check("R6 pin ignored done flag", st_done, 0);
        check("R6 pin ignored rx unchanged", rx_data, old);
        en = 1'b0;
        csn_in = 1'b1;
        cyc(2);
    endtask

    task automatic t_abort();
        logic [7:0] cap, old;
        set_cfg({3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1});
        clear_stat();
        old = rx_data;
        write_tx(8'hF0);
        en = 1'b1;
        csn_in = 1'b0;
        cyc(6);
        drive_bits(8'hFF, 3, cap);
        csn_in = 1'b1;
        cyc(6);
        check("R8 abort no done", st_done, 0);
        check("R8 abort rx unchanged", rx_data, old);
        write_tx(8'h2D);
        csn_in = 1'b0;
        cyc(6);
        drive_bits(8'h71, 8, cap);
        csn_in = 1'b1;
        cyc(4);
        check("R8 after abort rx_data", rx_data, 8'h71);
        check("R8 after abort sdo byte", cap, 8'h2D);
        en = 1'b0;
        cyc(2);
    endtask

    task automatic t_latency(logic byp);
        do_reset();
        set_cfg({3'b000, byp, 1'b1, 1'b1, 1'b0, 1'b1});
        write_tx(8'h80);
        en = 1'b1;
        csn_in = 1'b0;
        cyc(1);
        check("R7 select latency one clock", sdo, byp);
        cyc(2);
        check("R7 select latency three clocks", sdo, 1);
        csn_in = 1'b1;
        en = 1'b0;
        cyc(3);
    endtask

    initial begin
        t_reset();
        t_cfg_lock();
        t_latency(1'b1);
        t_latency(1'b0);
        t_master(0, 1'b1, 1'b0, 8'hA5, 8'h3C);
        t_master(2, 1'b0, 1'b1, 8'h81, 8'h7E);
        t_master(7, 1'b1, 1'b1, 8'h5B, 8'hC2);
        t_stat_clear();
        t_slave_ext(1'b1, 1'b0, 8'hC3, 8'h69);
        t_slave_ext(1'b0, 1'b1, 8'h1E, 8'hB4);
        t_ext_ignored();
        t_internal_sel();
        t_abort();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule